// File: doc/BRIEF.md
# Reconfigurable Two-Cell Logic Tile Array

This block is a small rectangular array of logic tiles. Each tile holds two configurable circuits: a master, which takes the tile's two external inputs, and a slave, which sits behind it. Each circuit can act as a two-input NAND gate, a rising-edge register or a transparent latch. The master has a second role. It can act as a routing switch that steers the output of one of the four adjacent tiles onto the slave's second input. Each neighbour link is gated by its own enable bit.

Configuration enters through one serial shift register shared by the whole array. A tile copies the shifted word into its own configuration only when its write-enable bit is high at a clock edge. One tile, a few tiles, or all tiles can therefore be rewritten while the others keep computing. Shifting on its own alters nothing. A synchronous reset clears every register and latch value. It leaves all configuration in place.

Tiles are numbered t = row*COLS + col. North is row-1, south is row+1, east is col+1 and west is col-1. A neighbour that would lie outside the array reads as 0.

Top module: `rcf_fabric`

## Requirements
- R1: A circuit whose 2-bit mode is 00 or 11 drives ~(a & b). The master's a and b are the tile's ext_a and ext_b bits.
- R2: A circuit in mode 01 drives the value its a input held at the previous rising clock edge.
- R3: A circuit in mode 10 drives a while its b input (the latch enable) is 1. It holds the last value passed while b is 0.
- R4: With the route bit (config bit 4) at 0, the slave's a input is the master's output and its b input is ext_b. m_out shows the master's output.
- R5: With the route bit at 1, the slave's a input is ext_a and its b input is the neighbour chosen by config bits [6:5] (0 north, 1 south, 2 east, 3 west). m_out shows that routed value.
- R6: Config bits 7, 8, 9 and 10 enable the north, south, east and west links. A disabled link, or a link that points off the array edge, reads 0.
- R7: On every clock edge with cfg_shift high, cfg_sin enters bit 0 of the 11-bit shift word and the other bits move up by one place. After 11 shifts the first bit sent sits in bit 10. The master mode is in bits [1:0] and the slave mode in bits [3:2]. Shifting by itself changes no tile's behaviour.
- R8: A clock edge with cfg_we[t] high loads the shift word, as it stood before that edge, into tile t only. Tiles whose write-enable is low keep running without interruption, even when a shift happens in the same cycle.
- R9: A clock edge with rst high clears the stored value of every circuit to 0. It keeps every tile's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear of cell state (configuration kept) |
| cfg_sin | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift enable for the configuration word |
| cfg_we | input | ROWS*COLS | Per-tile configuration write enable |
| ext_a | input | ROWS*COLS | Per-tile external input a |
| ext_b | input | ROWS*COLS | Per-tile external input b |
| m_out | output | ROWS*COLS | Per-tile master output (or routed value) |
| s_out | output | ROWS*COLS | Per-tile slave output, also fed to the neighbours |

## Verification
Two kinds of event can land on the same clock edge.

The first is a configuration write and a further shift. The bench holds cfg_shift and one tile's write-enable high together on a single edge. It then checks, through the tile's output, that the tile took the word as it stood before that shift. Two things confirm this: the tile's output matches NAND behaviour and not register behaviour, and the shifted word written afterwards to a second tile behaves as a register.

The second is a rewrite of one tile while another tile is in register mode. The bench changes the other tile's input on every cycle of the shift and the write. It compares that tile's output with the input applied one edge earlier.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

   localparam int CFG_W = 11;

   typedef enum logic [1:0] {
      MODE_NAND  = 2'b00,
      MODE_REG   = 2'b01,
      MODE_LATCH = 2'b10,
      MODE_ALT   = 2'b11
   } cell_mode_e;

   typedef enum logic [1:0] {
      DIR_N = 2'd0,
      DIR_S = 2'd1,
      DIR_E = 2'd2,
      DIR_W = 2'd3
   } dir_e;

   // bit 10..7 link enables (W,E,S,N), 6..5 select, 4 route, 3..2 slave, 1..0 master
   typedef struct packed {
      logic [3:0] link_en;
      dir_e       sel;
      logic       route;
      cell_mode_e s_mode;
      cell_mode_e m_mode;
   } tile_cfg_t;

endpackage

// File: rtl/rcf_cell.sv
module rcf_cell
   import rcf_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  cell_mode_e mode,
   input  logic       din_a,
   input  logic       din_b,
   output logic       y
);

   logic q;
   logic q_nxt;

   always_comb begin
      q_nxt = q;
      y     = ~(din_a & din_b);
      case (mode)
         MODE_REG: begin
            q_nxt = din_a;
            y     = q;
         end
         MODE_LATCH: begin
            if (din_b) q_nxt = din_a;
            y = din_b ? din_a : q;
         end
         default: begin
            q_nxt = q;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= q_nxt;
   end

   // R2: register mode shows the input sampled one edge earlier
   a_r2_reg_follows: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_REG) |=> ((mode != MODE_REG) || (y == $past(din_a))));

   // R3: closed latch keeps its output
   a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_LATCH && !din_b) |=> ((mode != MODE_LATCH) || din_b || (y == $past(y))));

endmodule

// File: rtl/rcf_nbr_mux.sv
module rcf_nbr_mux
   import rcf_pkg::*;
(
   input  logic [3:0] nbr,
   input  logic [3:0] link_en,
   input  dir_e       sel,
   output logic       routed
);

   logic [3:0] gated;

   always_comb begin
      gated  = nbr & link_en;
      routed = gated[sel];
   end

endmodule

// File: rtl/rcf_cfg_shift.sv
module rcf_cfg_shift #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift_en,
   input  logic         sin,
   output logic [W-1:0] word
);

   initial begin
      if (W < 2) $error("rcf_cfg_shift: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (shift_en) word <= {word[W-2:0], sin};
   end

   // R7: serial bit lands in bit 0
   a_r7_shift_in: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (word[0] == $past(sin)));

   // R7: word is steady without a shift
   a_r7_shift_idle: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(word));

endmodule

// File: rtl/rcf_tile.sv
module rcf_tile
   import rcf_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             ext_a,
   input  logic             ext_b,
   input  logic [3:0]       nbr,
   output logic             m_out,
   output logic             s_out
);

   tile_cfg_t cfg;
   logic      m_y;
   logic      routed;
   logic      s_a;
   logic      s_b;

   always_ff @(posedge clk) begin
      if (we) cfg <= tile_cfg_t'(cfg_word);
   end

   rcf_cell u_master (
      .clk   (clk),
      .rst   (rst),
      .mode  (cfg.m_mode),
      .din_a (ext_a),
      .din_b (ext_b),
      .y     (m_y)
   );

   rcf_nbr_mux u_switch (
      .nbr     (nbr),
      .link_en (cfg.link_en),
      .sel     (cfg.sel),
      .routed  (routed)
   );

   always_comb begin
      s_a   = cfg.route ? ext_a  : m_y;
      s_b   = cfg.route ? routed : ext_b;
      m_out = cfg.route ? routed : m_y;
   end

   rcf_cell u_slave (
      .clk   (clk),
      .rst   (rst),
      .mode  (cfg.s_mode),
      .din_a (s_a),
      .din_b (s_b),
      .y     (s_out)
   );

   // R8: configuration changes only on a write
   a_r8_cfg_kept: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(cfg));

   // R6: disabled link reads 0 at the master output
   a_r6_link_off: assert property (@(posedge clk) disable iff (rst)
      (cfg.route && !cfg.link_en[cfg.sel]) |-> !m_out);

endmodule

// File: rtl/rcf_fabric.sv
module rcf_fabric
   import rcf_pkg::*;
#(
   parameter int ROWS = 2,
   parameter int COLS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_sin,
   input  logic                 cfg_shift,
   input  logic [ROWS*COLS-1:0] cfg_we,
   input  logic [ROWS*COLS-1:0] ext_a,
   input  logic [ROWS*COLS-1:0] ext_b,
   output logic [ROWS*COLS-1:0] m_out,
   output logic [ROWS*COLS-1:0] s_out
);

   localparam int N_TILES = ROWS * COLS;

   if (ROWS < 1 || COLS < 1) begin : g_bad_dims
      $error("rcf_fabric: ROWS and COLS must be positive");
   end
   if (N_TILES > 1024) begin : g_bad_size
      $error("rcf_fabric: array too large");
   end

   logic [CFG_W-1:0] cfg_word;

   rcf_cfg_shift #(.W(CFG_W)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_shift),
      .sin      (cfg_sin),
      .word     (cfg_word)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;
         logic [3:0] nbr;

         if (r > 0) begin : g_n
            assign nbr[DIR_N] = s_out[IDX - COLS];
         end else begin : g_n_edge
            assign nbr[DIR_N] = 1'b0;
         end
         if (r < ROWS - 1) begin : g_s
            assign nbr[DIR_S] = s_out[IDX + COLS];
         end else begin : g_s_edge
            assign nbr[DIR_S] = 1'b0;
         end
         if (c < COLS - 1) begin : g_e
            assign nbr[DIR_E] = s_out[IDX + 1];
         end else begin : g_e_edge
            assign nbr[DIR_E] = 1'b0;
         end
         if (c > 0) begin : g_w
            assign nbr[DIR_W] = s_out[IDX - 1];
         end else begin : g_w_edge
            assign nbr[DIR_W] = 1'b0;
         end

         rcf_tile u_tile (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we[IDX]),
            .cfg_word (cfg_word),
            .ext_a    (ext_a[IDX]),
            .ext_b    (ext_b[IDX]),
            .nbr      (nbr),
            .m_out    (m_out[IDX]),
            .s_out    (s_out[IDX])
         );
      end
   end

endmodule

// File: tb/rcf_fabric_test.sv
module rcf_fabric_test;

   localparam int NT = 4;
   localparam int W  = 11;

   logic          clk = 1'b0;
   logic          rst;
   logic          cfg_sin;
   logic          cfg_shift;
   logic [NT-1:0] cfg_we;
   logic [NT-1:0] ext_a;
   logic [NT-1:0] ext_b;
   logic [NT-1:0] m_out;
   logic [NT-1:0] s_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rcf_fabric #(.ROWS(2), .COLS(2)) uut (
      .clk       (clk),
      .rst       (rst),
      .cfg_sin   (cfg_sin),
      .cfg_shift (cfg_shift),
      .cfg_we    (cfg_we),
      .ext_a     (ext_a),
      .ext_b     (ext_b),
      .m_out     (m_out),
      .s_out     (s_out)
   );

   task automatic check(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mk(input logic [1:0] mm, input logic [1:0] sm,
                                       input logic route, input logic [1:0] sel,
                                       input logic [3:0] links);
      return {links, sel, route, sm, mm};
   endfunction

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic shift_word(input logic [W-1:0] w);
      for (int i = W - 1; i >= 0; i--) begin
         cfg_sin   = w[i];
         cfg_shift = 1'b1;
         tick();
      end
      cfg_shift = 1'b0;
   endtask

   task automatic load(input logic [W-1:0] w, input logic [NT-1:0] mask);
      shift_word(w);
      cfg_we = mask;
      tick();
      cfg_we = '0;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [NT-1:0] prev, held, a, b, em, es;
      logic          rt, s1, s2;
      rst = 1'b1; cfg_sin = 1'b0; cfg_shift = 1'b0; cfg_we = '0;
      ext_a = '0; ext_b = '0;
      tick(); tick();

      // R9: reset state with everything in register mode
      load(mk(2'b01, 2'b01, 1'b0, 2'd0, 4'h0), 4'hF);
      ext_a = 4'hF;
      tick();
      check("R9 reset master", m_out, 4'h0);
      check("R9 reset slave", s_out, 4'h0);
      rst = 1'b0;

      // R2 / R4: master registers ext_a, slave registers master output
      prev = 4'h0;
      for (int v = 0; v < 16; v++) begin
         ext_a = v[3:0];
         tick();
         check("R2 master reg", m_out, v[3:0]);
         check("R4 slave follows master", s_out, prev);
         prev = v[3:0];
      end

      // R9: reset clears state, keeps configuration
      rst = 1'b1; tick(); rst = 1'b0;
      check("R9 cleared", m_out, 4'h0);
      ext_a = 4'h5;
      tick();
      check("R9 config kept", m_out, 4'h5);

      // R1 / R4: NAND exhaustive, then mode 11
      for (int md = 0; md < 4; md += 3) begin
         load(mk(md[1:0], md[1:0], 1'b0, 2'd0, 4'h0), 4'hF);
         for (int v = 0; v < 256; v++) begin
            ext_a = v[3:0]; ext_b = v[7:4];
            #1;
            em = ~(ext_a & ext_b);
            es = ~(em & ext_b);
            check("R1 nand master", m_out, em);
            check("R4 nand slave", s_out, es);
         end
      end

      // R3: latch sweep
      load(mk(2'b10, 2'b00, 1'b0, 2'd0, 4'h0), 4'hF);
      rst = 1'b1; tick(); rst = 1'b0;
      held = 4'h0;
      for (int v = 0; v < 256; v++) begin
         a = v[3:0] ^ v[7:4]; b = v[7:4];
         ext_a = a; ext_b = b;
         #1;
         em = (b & a) | (~b & held);
         check("R3 latch", m_out, em);
         tick();
         held = em;
         check("R3 latch after edge", m_out, em);
      end

      // R5 / R6: tile 0 routes, others plain NAND pairs
      load(mk(2'b00, 2'b00, 1'b0, 2'd0, 4'h0), 4'b1110);
      for (int sel = 0; sel < 4; sel++) begin
         for (int lk = 0; lk < 16; lk++) begin
            load(mk(2'b00, 2'b00, 1'b1, sel[1:0], lk[3:0]), 4'b0001);
            for (int v = 0; v < 64; v++) begin
               ext_a = v[3:0]; ext_b = {v[5:4], 2'b00};
               #1;
               s1 = ~(~(ext_a[1] & ext_b[1]) & ext_b[1]);
               s2 = ~(~(ext_a[2] & ext_b[2]) & ext_b[2]);
               case (sel)
                  1: rt = s2 & lk[1];
                  2: rt = s1 & lk[2];
                  default: rt = 1'b0;
               endcase
               check("R5 R6 routed", {3'b000, m_out[0]}, {3'b000, rt});
               check("R5 slave uses route", {3'b000, s_out[0]}, {3'b000, ~(ext_a[0] & rt)});
            end
         end
      end

      // R7 / R8: rewrite tile 0 while tile 1 keeps registering
      load(mk(2'b00, 2'b00, 1'b0, 2'd0, 4'h0), 4'b0001);
      load(mk(2'b01, 2'b00, 1'b0, 2'd0, 4'h0), 4'b0010);
      ext_a[0] = 1'b1; ext_b[0] = 1'b1;
      for (int i = W - 1; i >= 0; i--) begin
         cfg_sin = mk(2'b01, 2'b00, 1'b0, 2'd0, 4'h0) >> i;
         cfg_shift = 1'b1;
         ext_a[1] = i[0];
         tick();
         check("R8 neighbour runs", {3'b000, m_out[1]}, {3'b000, i[0]});
         check("R7 shift leaves tile", {3'b000, m_out[0]}, 4'h0);
      end
      cfg_shift = 1'b0;
      cfg_we = 4'b0001; ext_a[1] = 1'b1;
      tick();
      cfg_we = '0;
      check("R8 neighbour during write", {3'b000, m_out[1]}, 4'h1);
      tick();
      check("R8 rewritten tile registers", {3'b000, m_out[0]}, 4'h1);
      ext_a[0] = 1'b0;
      #1;
      check("R8 rewritten tile holds", {3'b000, m_out[0]}, 4'h1);
      tick();
      check("R8 rewritten tile captures", {3'b000, m_out[0]}, 4'h0);

      // R8 / R7: write and shift on the same edge
      rst = 1'b1; tick(); rst = 1'b0;
      shift_word('0);
      cfg_sin = 1'b1; cfg_shift = 1'b1; cfg_we = 4'b0100;
      tick();
      cfg_shift = 1'b0; cfg_we = '0;
      ext_a[2] = 1'b0; ext_b[2] = 1'b0;
      #1;
      check("R8 pre-shift word taken", {3'b000, m_out[2]}, 4'h1);
      cfg_we = 4'b1000;
      tick();
      cfg_we = '0;
      ext_a[3] = 1'b1; ext_b[3] = 1'b1;
      tick();
      check("R7 bit 0 is master mode lsb", {3'b000, m_out[3]}, 4'h1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule